// File: doc/BRIEF.md
# System Counter Fractional Prescaler

This block drives a shared 64-bit free-running system counter. The counter advances from one of two clock-enable inputs. One is a strobe from a crystal-derived reference. The other is a strobe from a core-derived clock. Both are already synchronous to `clk`. A fractional phase accumulator sits between the chosen strobe and the counter. It sets the count rate to the input rate times 2^31 divided by a 32-bit prescaler value. A prescaler of 0x80000000 therefore gives one count per input strobe, and larger values give proportionally slower, non-integer rates.

A small word-addressed register port holds two registers. The control register (word 0) picks the input source and the count step per tick. The prescaler register (word 1) holds the divisor. The block outputs the running 64-bit count and a one-cycle tick strobe that marks each cycle in which the count changed. The count wraps modulo 2^64.

Top module: `tsp_prescaler`

## Requirements
- R1: After a synchronous reset the control register reads 0, the prescaler reads 0x80000000, `sys_count` is 0 and `sys_tick` is low.
- R2: A write with `reg_we` high to word 0 stores control bits 8 and 9; all other control bits read back as 0. A write to word 1 stores the full 32-bit prescaler. `reg_rdata` shows the addressed register in the same cycle, and other addresses read 0.
- R3: Control bit 8 clear selects `xtal_en` as the input strobe, and set selects `core_en`. Pulses on the unselected input have no effect on the count.
- R4: Control bit 9 clear makes each tick add 1 to the count, and set makes it add 2.
- R5: `sys_tick` and `sys_count` are registered. They change one clock after the edge that sampled the enabling strobe. The count changes only in cycles where `sys_tick` is high.
- R6: For a prescaler P of at least 0x80000000, each selected strobe adds 2^31 to a 32-bit phase. A tick occurs when the phase reaches P, and P is then taken off. For example, P = 0xC0000000 gives the pattern no-tick, tick, tick per three strobes, starting from a cleared phase.
- R7: With P = 0x80000000 every selected strobe produces a tick.
- R8: With P = 0 no tick occurs and the count holds.
- R9: With P between 1 and 0x7FFFFFFF every selected strobe produces a tick (at most one per clock) and the phase is kept at 0.
- R10: A write to the prescaler clears the phase and suppresses any tick in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | Crystal reference strobe |
| core_en | input | 1 | Core-derived strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sys_count | output | 64 | Running system count |
| sys_tick | output | 1 | One-cycle strobe when the count advances |

## Verification
The hardest case to reach is a prescaler write that lands in the same cycle as a selected strobe while the phase holds a nonzero remainder. That collision is the only thing that separates "clear and suppress" from "tick then clear". The stimulus gets there by programming 0xC0000000 and giving one strobe, which leaves half a step of phase behind. It then rewrites the same prescaler value together with a strobe. The scoreboard expects no tick at that point, followed by a fresh no-tick, tick, tick pattern.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int DATA_W     = 32;
    localparam int COUNT_W    = 64;
    localparam int ADDR_W     = 2;
    localparam int SRC_BIT    = 8;
    localparam int STEP_BIT   = 9;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 2'd1;
    localparam logic [DATA_W-1:0] PHASE_HALF = 32'h8000_0000;
    localparam logic [DATA_W-1:0] PRESC_RST  = 32'h8000_0000;

    typedef struct packed {
        logic step2;
        logic alt_src;
    } ctrl_t;

    typedef struct packed {
        logic              adv;
        logic [DATA_W-1:0] next;
    } phase_res_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRC_BIT]  = c.alt_src;
        w[STEP_BIT] = c.step2;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.alt_src = w[SRC_BIT];
        c.step2   = w[STEP_BIT];
        return c;
    endfunction

    function automatic phase_res_t phase_step(logic [DATA_W-1:0] acc,
                                              logic [DATA_W-1:0] presc);
        phase_res_t r;
        logic [DATA_W:0] sum;
        logic [DATA_W:0] rem;
        sum = {1'b0, acc} + {1'b0, PHASE_HALF};
        rem = sum - {1'b0, presc};
        r.adv  = 1'b0;
        r.next = acc;
        if (presc == '0) begin
            r.adv  = 1'b0;
            r.next = acc;
        end else if (presc < PHASE_HALF) begin
            r.adv  = 1'b1;
            r.next = '0;
        end else if (sum >= {1'b0, presc}) begin
            r.adv  = 1'b1;
            r.next = rem[DATA_W-1:0];
        end else begin
            r.adv  = 1'b0;
            r.next = sum[DATA_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/tsp_regs.sv
module tsp_regs
    import tsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] presc,
    output logic              presc_wr
);

    ctrl_t             ctrl_r;
    logic [DATA_W-1:0] presc_r;
    logic              ctrl_wr;

    assign ctrl_wr  = we && (addr == ADDR_CTRL);
    assign presc_wr = we && (addr == ADDR_PRESC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r  <= '0;
            presc_r <= PRESC_RST;
        end else begin
            if (ctrl_wr)  ctrl_r  <= ctrl_unpack(wdata);
            if (presc_wr) presc_r <= wdata;
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL:  rdata = ctrl_pack(ctrl_r);
            ADDR_PRESC: rdata = presc_r;
            default:    rdata = '0;
        endcase
    end

    assign ctrl  = ctrl_r;
    assign presc = presc_r;

endmodule

// File: rtl/tsp_phase.sv
module tsp_phase
    import tsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] presc,
    input  logic              presc_wr,
    output logic              adv
);

    logic [DATA_W-1:0] acc;
    phase_res_t        res;

    always_comb begin
        res = phase_step(acc, presc);
        adv = en && !presc_wr && res.adv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (presc_wr) begin
            acc <= '0;
        end else if (en) begin
            acc <= res.next;
        end
    end

endmodule

// File: rtl/tsp_counter.sv
module tsp_counter
    import tsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               step2,
    output logic [COUNT_W-1:0] count,
    output logic               tick
);

    logic [COUNT_W-1:0] inc;

    assign inc = step2 ? COUNT_W'(2) : COUNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= adv;
            if (adv) count <= count + inc;
        end
    end

endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler
    import tsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               xtal_en,
    input  logic               core_en,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [COUNT_W-1:0] sys_count,
    output logic               sys_tick
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] presc_q;
    logic              presc_wr;
    logic              src_en;
    logic              adv;

    tsp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl_q),
        .presc    (presc_q),
        .presc_wr (presc_wr)
    );

    assign src_en = ctrl_q.alt_src ? core_en : xtal_en;

    tsp_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (src_en),
        .presc    (presc_q),
        .presc_wr (presc_wr),
        .adv      (adv)
    );

    tsp_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .step2 (ctrl_q.step2),
        .count (sys_count),
        .tick  (sys_tick)
    );

endmodule

// File: rtl/tsp_prescaler_chk.sv
module tsp_prescaler_chk
    import tsp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               xtal_en,
    input logic               core_en,
    input logic               alt_src,
    input logic               step2,
    input logic [DATA_W-1:0]  presc,
    input logic               presc_wr,
    input logic [COUNT_W-1:0] sys_count,
    input logic               sys_tick
);

    logic sel;
    assign sel = alt_src ? core_en : xtal_en;

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        sys_tick |-> (sys_count == $past(sys_count) + ($past(step2) ? 64'd2 : 64'd1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !sys_tick |-> (sys_count == $past(sys_count)));

    assert_source_R3: assert property (@(posedge clk) disable iff (rst)
        sys_tick |-> $past(sel));

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(presc) == 32'd0) |-> !sys_tick);

    assert_unity_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(presc) == PHASE_HALF && !$past(presc_wr) && $past(sel))
        |-> sys_tick);

    assert_wrclr_R10: assert property (@(posedge clk) disable iff (rst)
        $past(presc_wr) |-> !sys_tick);

endmodule

bind tsp_prescaler tsp_prescaler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .xtal_en   (xtal_en),
    .core_en   (core_en),
    .alt_src   (ctrl_q.alt_src),
    .step2     (ctrl_q.step2),
    .presc     (presc_q),
    .presc_wr  (presc_wr),
    .sys_count (sys_count),
    .sys_tick  (sys_tick)
);

// File: tb/sim_tsp_prescaler.sv
`timescale 1ns/1ps
module sim_tsp_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xtal_en = 1'b0;
    logic        core_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [63:0] sys_count;
    logic        sys_tick;

    always #5 clk = ~clk;

    tsp_prescaler u0 (
        .clk(clk), .rst(rst), .xtal_en(xtal_en), .core_en(core_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_count(sys_count), .sys_tick(sys_tick)
    );

    typedef struct {
        logic [63:0] cnt;
        string       req;
    } exp_t;

    exp_t expq[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic        m_alt  = 0;
    logic        m_step = 0;
    logic [31:0] m_p    = 32'h8000_0000;
    logic [32:0] m_acc  = 0;
    logic [63:0] m_cnt  = 0;
    string       cur_req = "R7";

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop one expected item per observed tick
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sys_tick) begin
                if (expq.size() == 0) begin
                    n_run++; n_fail++;
                    $display("FAIL R5 actual=unexpected tick count=%0h expected=no tick", sys_count);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check64(e.req, sys_count, e.cnt);
                end
            end
        end
    end

    // driver: one clock of stimulus; expected items pushed from the model
    task automatic cyc(logic xe, logic ce, logic we, logic [1:0] a, logic [31:0] d);
        logic  sel;
        logic  t;
        exp_t  e;
        @(negedge clk);
        xtal_en = xe; core_en = ce; reg_we = we; reg_addr = a; reg_wdata = d;
        sel = m_alt ? ce : xe;
        t = 0;
        if (we && a == 2'd1) begin
            m_acc = 0;
        end else if (sel && m_p != 0) begin
            if (m_p < 32'h8000_0000) begin
                t = 1; m_acc = 0;
            end else if (m_acc + 33'h0_8000_0000 >= {1'b0, m_p}) begin
                t = 1; m_acc = m_acc + 33'h0_8000_0000 - {1'b0, m_p};
            end else begin
                m_acc = m_acc + 33'h0_8000_0000;
            end
        end
        if (t) begin
            m_cnt = m_cnt + (m_step ? 64'd2 : 64'd1);
            e.cnt = m_cnt; e.req = cur_req;
            expq.push_back(e);
        end
        if (we && a == 2'd0) begin m_alt = d[8]; m_step = d[9]; end
        if (we && a == 2'd1) m_p = d;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 2'd0, 32'd0);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cyc(0, 0, 1, a, d);
        idle();
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_we = 0; reg_addr = a; xtal_en = 0; core_en = 0;
        #1 check64(req, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic drain(string req);
        idle(); idle();
        n_run++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL %s actual=%0d pending ticks expected=0", req, expq.size());
            expq.delete();
        end
        check64(req, sys_count, m_cnt);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        #1;
        check64("R1", sys_count, 64'd0);
        check64("R1", {63'd0, sys_tick}, 64'd0);
        rd_check("R1", 2'd0, 32'd0);
        rd_check("R1", 2'd1, 32'h8000_0000);

        // R7 unity prescaler, crystal source, step 1
        cur_req = "R7";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R7");

        // R2 register access
        wr(2'd0, 32'hFFFF_FFFF);
        rd_check("R2", 2'd0, 32'h0000_0300);
        rd_check("R2", 2'd2, 32'd0);

        // R3 unselected crystal strobes ignored while core source active
        cur_req = "R3";
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R3");
        // R4 core source with step 2
        cur_req = "R4";
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 2'd0, 32'd0);
        drain("R4");

        // back to crystal, step 1; R3 core strobes ignored
        wr(2'd0, 32'd0);
        cur_req = "R3";
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 2'd0, 32'd0);
        drain("R3");

        // R6 fractional 2/3 rate
        wr(2'd1, 32'hC000_0000);
        rd_check("R2", 2'd1, 32'hC000_0000);
        cur_req = "R6";
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R6");
        // R6 near one half rate, strobes with gaps
        wr(2'd1, 32'hFFFF_FFFF);
        for (int i = 0; i < 10; i++) begin
            cyc(1, 0, 0, 2'd0, 32'd0);
            if (i % 3 == 0) idle();
        end
        drain("R6");

        // R9 small prescaler ticks each strobe
        wr(2'd1, 32'h4000_0000);
        cur_req = "R9";
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R9");

        // R10 write collides with strobe while phase is nonzero
        wr(2'd1, 32'hC000_0000);
        cur_req = "R10";
        cyc(1, 0, 0, 2'd0, 32'd0);
        cyc(1, 0, 1, 2'd1, 32'hC000_0000);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R10");

        // R8 zero prescaler stops the count
        wr(2'd1, 32'd0);
        cur_req = "R8";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'd0, 32'd0);
        drain("R8");

        // R5 step 2 on crystal, single strobe then quiet
        wr(2'd1, 32'h8000_0000);
        wr(2'd0, 32'h0000_0200);
        cur_req = "R5";
        cyc(1, 0, 0, 2'd0, 32'd0);
        idle(); idle(); idle();
        drain("R5");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule